// File: doc/BRIEF.md
# Page-Crossing Load Splitter

This block sits between a load pipeline and a translating memory port. A load arrives as a byte address and a size of 1, 2, 4 or 8 bytes. The block checks whether the bytes run past the end of the 4 KB page that holds the start address. A load that stays inside one page goes straight through to the downstream port as one sub-request, in the same cycle and with no added latency. A load that spills over is cut in two. The part up to the page end is sent first. The part that starts at the next page base is sent only after the first part has come back without a fault. Each part is translated by the downstream port on its own, so the two physical locations need not be next to each other. The returned bytes are put back together little-endian, in virtual address order.

A fault on either part ends the whole load. The result then carries a fault flag, zero data and the virtual address of the part that failed. All three data-carrying interfaces use valid/ready. A payload whose valid is high must stay stable until ready is seen high at a clock edge. The load input is refused, with `req_ready` low, while `busy` is high. The downstream response is consumed only when `sub_rsp_ready` is high. For a pass-through load that signal follows `res_ready`, so back-pressure on the result stalls the response in place. For a split load the block takes each response at once and holds the merged result in a register until `res_ready`.

Top module: `page_split_unit`

## Requirements
- R1: A load whose start offset plus byte count is at most 4096 is issued as a single sub-request in the cycle it is presented. `sub_valid` follows `req_valid`, `sub_vaddr` equals `req_addr`, `sub_nbytes` equals the byte count, and `req_ready` equals `sub_ready` while idle.
- R2: A load is split exactly when start offset (address bits 11:0) plus byte count exceeds 4096. A load ending on the last byte of a page (offset 0xFF8 with 8 bytes) is not split.
- R3: The first part of a split load starts at the load address and carries 4096 minus the start offset bytes. It is the first sub-request issued for that load. No sub-request ever runs past the end of its page.
- R4: The second part starts at the base of the following page, wrapping from the top of the address space to address 0. It carries the remaining bytes and is issued only after the first part's response has been taken without a fault. Its payload stays stable while it waits for `sub_ready`.
- R5: Result byte lane k (bits 8k+7:8k) holds the byte at virtual address start+k, for k below the byte count. Lanes at or above the byte count are zero. In the responses, lane k holds the byte at `sub_vaddr`+k, and lanes beyond `sub_nbytes` are ignored.
- R6: A fault on the first part, or on a pass-through load, gives `res_fault`=1, `res_fault_addr` equal to the load address, and zero `res_data`. No second part is issued.
- R7: A fault on the second part gives `res_fault`=1, `res_fault_addr` equal to the next page base, and zero data.
- R8: `busy` rises on the cycle after a load is accepted and stays high until its result handshake completes. While `busy` is high, `req_ready` is low.
- R9: While `res_valid` is high and `res_ready` is low, the result is held stable. For a pass-through load, `sub_rsp_ready` equals `res_ready`. For a split load it is high while a part's response is awaited.
- R10: `req_size` encodes the byte count as 0→1, 1→2, 2→4, 3→8. `sub_nbytes` is always between 1 and 8.
- R11: After reset the block is idle: `busy`=0, `res_valid`=0, and `sub_valid` is low unless `req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Load request valid |
| req_ready | output | 1 | Load request accepted |
| req_addr | input | 32 | Virtual byte address of the load |
| req_size | input | 2 | log2 of the byte count |
| busy | output | 1 | A load is in flight |
| sub_valid | output | 1 | Sub-request valid |
| sub_ready | input | 1 | Sub-request accepted by the translating port |
| sub_vaddr | output | 32 | Virtual start address of the sub-request |
| sub_nbytes | output | 4 | Byte count of the sub-request |
| sub_rsp_valid | input | 1 | Sub-response valid |
| sub_rsp_ready | output | 1 | Sub-response taken |
| sub_rsp_data | input | 64 | Sub-response bytes, lane 0 at the sub-request address |
| sub_rsp_fault | input | 1 | Translation fault for the sub-request |
| res_valid | output | 1 | Merged result valid |
| res_ready | input | 1 | Merged result taken |
| res_data | output | 64 | Merged little-endian load data |
| res_fault | output | 1 | Load aborted by a fault |
| res_fault_addr | output | 32 | Virtual address of the faulting part |

## Verification
For a pass-through load, taking the downstream response and delivering the result fall in the same cycle, because one handshake drives the other. The bench provokes this by toggling `res_ready` pseudo-randomly while a response is held valid. Its reference model then checks every cycle that `sub_rsp_ready` tracks `res_ready` and that the response is consumed only in the cycle the result is taken. A second coincidence is a first-part fault arriving in the cycle the second part would be launched. Loads that start just below a faulting page, or just below a clean page that is followed by a faulting one, show whether the second part is suppressed or issued, and which virtual address is reported.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,    // ready for a new load
    ST_ONE,     // pass-through load awaiting its response
    ST_A_WAIT,  // first part of a split awaiting its response
    ST_B_ISSUE, // second part offered downstream
    ST_B_WAIT,  // second part awaiting its response
    ST_OUT      // merged result held for the consumer
  } pcs_state_e;
endpackage

// File: rtl/pcs_span_calc.sv
module pcs_span_calc #(
  parameter int VA_W       = 32,
  parameter int PAGE_BITS  = 12,
  parameter int DATA_BYTES = 8,
  parameter int SZ_W       = $clog2($clog2(DATA_BYTES) + 1),
  parameter int CNT_W      = $clog2(DATA_BYTES + 1)
) (
  input  logic [VA_W-1:0]  addr,
  input  logic [SZ_W-1:0]  size_log2,
  output logic [CNT_W-1:0] nbytes,
  output logic             crosses,
  output logic [CNT_W-1:0] first_n,
  output logic [VA_W-1:0]  next_page
);
  localparam int PN_W = VA_W - PAGE_BITS;
  localparam logic [PAGE_BITS:0] PAGE_SIZE = (PAGE_BITS+1)'(1) << PAGE_BITS;

  logic [PAGE_BITS:0] off_ext;
  logic [PAGE_BITS:0] span_end;
  logic [PAGE_BITS:0] room;
  logic [PN_W-1:0]    pn_next;

  always_comb begin
    nbytes    = CNT_W'(1) << size_log2;
    off_ext   = {1'b0, addr[PAGE_BITS-1:0]};
    span_end  = off_ext + (PAGE_BITS+1)'(nbytes);
    crosses   = span_end > PAGE_SIZE;
    room      = PAGE_SIZE - off_ext;
    first_n   = crosses ? CNT_W'(room) : nbytes;
    pn_next   = addr[VA_W-1:PAGE_BITS] + PN_W'(1);
    next_page = {pn_next, {PAGE_BITS{1'b0}}};
  end
endmodule

// File: rtl/pcs_lane_merge.sv
module pcs_lane_merge #(
  parameter int DATA_BYTES = 8,
  parameter int CNT_W      = $clog2(DATA_BYTES + 1)
) (
  input  logic [8*DATA_BYTES-1:0] lo_data,
  input  logic [CNT_W-1:0]        lo_n,
  input  logic [8*DATA_BYTES-1:0] hi_data,
  input  logic [CNT_W-1:0]        total_n,
  output logic [8*DATA_BYTES-1:0] merged
);
  logic [8*DATA_BYTES-1:0] hi_shift;
  assign hi_shift = hi_data << {lo_n, 3'b000};

  for (genvar i = 0; i < DATA_BYTES; i++) begin : g_lane
    assign merged[8*i +: 8] = (CNT_W'(i) >= total_n) ? 8'h00 :
                              (CNT_W'(i) <  lo_n)    ? lo_data[8*i +: 8] :
                                                       hi_shift[8*i +: 8];
  end
endmodule

// File: rtl/page_split_unit.sv
module page_split_unit #(
  parameter int VA_W       = 32,
  parameter int PAGE_BITS  = 12,
  parameter int DATA_BYTES = 8,
  parameter int SZ_W       = $clog2($clog2(DATA_BYTES) + 1),
  parameter int CNT_W      = $clog2(DATA_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [VA_W-1:0]         req_addr,
  input  logic [SZ_W-1:0]         req_size,
  output logic                    busy,
  output logic                    sub_valid,
  input  logic                    sub_ready,
  output logic [VA_W-1:0]         sub_vaddr,
  output logic [CNT_W-1:0]        sub_nbytes,
  input  logic                    sub_rsp_valid,
  output logic                    sub_rsp_ready,
  input  logic [8*DATA_BYTES-1:0] sub_rsp_data,
  input  logic                    sub_rsp_fault,
  output logic                    res_valid,
  input  logic                    res_ready,
  output logic [8*DATA_BYTES-1:0] res_data,
  output logic                    res_fault,
  output logic [VA_W-1:0]         res_fault_addr
);
  import pcs_pkg::*;

  localparam int DW = 8 * DATA_BYTES;

  pcs_state_e         st;
  logic [VA_W-1:0]    addr_q, next_q;
  logic [CNT_W-1:0]   tot_q, first_q;
  logic [DW-1:0]      lo_q, out_data_q;
  logic               out_fault_q;
  logic [VA_W-1:0]    out_faddr_q;

  logic [CNT_W-1:0]   cur_n, cur_first;
  logic               cur_cross;
  logic [VA_W-1:0]    cur_next;
  logic [DW-1:0]      mg_lo, merged;
  logic [CNT_W-1:0]   mg_lo_n;

  pcs_span_calc #(
    .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .DATA_BYTES(DATA_BYTES),
    .SZ_W(SZ_W), .CNT_W(CNT_W)
  ) u_span (
    .addr(req_addr), .size_log2(req_size), .nbytes(cur_n),
    .crosses(cur_cross), .first_n(cur_first), .next_page(cur_next)
  );

  pcs_lane_merge #(.DATA_BYTES(DATA_BYTES), .CNT_W(CNT_W)) u_merge (
    .lo_data(mg_lo), .lo_n(mg_lo_n), .hi_data(sub_rsp_data),
    .total_n(tot_q), .merged(merged)
  );

  assign busy = (st != ST_IDLE);

  always_comb begin
    req_ready      = 1'b0;
    sub_valid      = 1'b0;
    sub_vaddr      = req_addr;
    sub_nbytes     = cur_first;
    sub_rsp_ready  = 1'b0;
    res_valid      = 1'b0;
    res_data       = out_data_q;
    res_fault      = out_fault_q;
    res_fault_addr = out_faddr_q;
    mg_lo          = sub_rsp_data;
    mg_lo_n        = tot_q;
    unique case (st)
      ST_IDLE: begin
        sub_valid = req_valid;
        req_ready = sub_ready;
      end
      ST_ONE: begin
        sub_rsp_ready  = res_ready;
        res_valid      = sub_rsp_valid;
        res_fault      = sub_rsp_fault;
        res_fault_addr = addr_q;
        res_data       = sub_rsp_fault ? '0 : merged;
      end
      ST_A_WAIT: sub_rsp_ready = 1'b1;
      ST_B_ISSUE: begin
        sub_valid  = 1'b1;
        sub_vaddr  = next_q;
        sub_nbytes = tot_q - first_q;
      end
      ST_B_WAIT: begin
        sub_rsp_ready = 1'b1;
        mg_lo         = lo_q;
        mg_lo_n       = first_q;
      end
      ST_OUT: res_valid = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      addr_q      <= '0;
      next_q      <= '0;
      tot_q       <= '0;
      first_q     <= '0;
      lo_q        <= '0;
      out_data_q  <= '0;
      out_fault_q <= 1'b0;
      out_faddr_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid && sub_ready) begin
          addr_q  <= req_addr;
          next_q  <= cur_next;
          tot_q   <= cur_n;
          first_q <= cur_first;
          st      <= cur_cross ? ST_A_WAIT : ST_ONE;
        end
        ST_ONE: if (sub_rsp_valid && res_ready) st <= ST_IDLE;
        ST_A_WAIT: if (sub_rsp_valid) begin
          if (sub_rsp_fault) begin
            out_fault_q <= 1'b1;
            out_faddr_q <= addr_q;
            out_data_q  <= '0;
            st          <= ST_OUT;
          end else begin
            lo_q <= sub_rsp_data;
            st   <= ST_B_ISSUE;
          end
        end
        ST_B_ISSUE: if (sub_ready) st <= ST_B_WAIT;
        ST_B_WAIT: if (sub_rsp_valid) begin
          out_fault_q <= sub_rsp_fault;
          out_faddr_q <= next_q;
          out_data_q  <= sub_rsp_fault ? '0 : merged;
          st          <= ST_OUT;
        end
        ST_OUT: if (res_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/page_split_unit_chk.sv
module page_split_unit_chk #(
  parameter int VA_W       = 32,
  parameter int PAGE_BITS  = 12,
  parameter int DATA_BYTES = 8,
  parameter int CNT_W      = $clog2(DATA_BYTES + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    busy,
  input logic                    sub_valid,
  input logic                    sub_ready,
  input logic [VA_W-1:0]         sub_vaddr,
  input logic [CNT_W-1:0]        sub_nbytes,
  input logic                    res_valid,
  input logic                    res_ready,
  input logic [8*DATA_BYTES-1:0] res_data,
  input logic                    res_fault,
  input logic [VA_W-1:0]         res_fault_addr
);
  localparam logic [PAGE_BITS:0] PG = (PAGE_BITS+1)'(1) << PAGE_BITS;

  AST_BUSY_GATES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R8

  AST_BUSY_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready)); // R8

  AST_SUB_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> ({1'b0, sub_vaddr[PAGE_BITS-1:0]} + (PAGE_BITS+1)'(sub_nbytes)) <= PG); // R3

  AST_SUB_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> (sub_nbytes != '0) && (sub_nbytes <= CNT_W'(DATA_BYTES))); // R10

  AST_SECOND_PART_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && !sub_ready && busy) |=> sub_valid && $stable(sub_vaddr) && $stable(sub_nbytes)); // R4

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && busy) |=> res_valid && $stable(res_data) &&
      $stable(res_fault) && $stable(res_fault_addr)); // R9

  AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> res_data == '0); // R6
endmodule

bind page_split_unit page_split_unit_chk #(
  .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .DATA_BYTES(DATA_BYTES), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/page_split_unit_tb.sv
module page_split_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        busy;
  logic        sub_valid, sub_ready = 1'b0;
  logic [31:0] sub_vaddr;
  logic [3:0]  sub_nbytes;
  logic        sub_rsp_valid = 1'b0, sub_rsp_ready;
  logic [63:0] sub_rsp_data = '0;
  logic        sub_rsp_fault = 1'b0;
  logic        res_valid, res_ready = 1'b0;
  logic [63:0] res_data;
  logic        res_fault;
  logic [31:0] res_fault_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_split_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_size(req_size),
    .busy(busy),
    .sub_valid(sub_valid), .sub_ready(sub_ready), .sub_vaddr(sub_vaddr), .sub_nbytes(sub_nbytes),
    .sub_rsp_valid(sub_rsp_valid), .sub_rsp_ready(sub_rsp_ready),
    .sub_rsp_data(sub_rsp_data), .sub_rsp_fault(sub_rsp_fault),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_fault(res_fault), .res_fault_addr(res_fault_addr)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // environment: address translation and memory contents
  function automatic logic [31:0] phys(input logic [31:0] va);
    return {va[31:12] ^ 20'h5A5C3, va[11:0]};
  endfunction
  function automatic logic [7:0] byte_at(input logic [31:0] va);
    logic [31:0] p;
    p = phys(va);
    return p[7:0] ^ p[15:8] ^ p[23:16] ^ 8'h3C;
  endfunction
  function automatic bit bad_page(input logic [31:0] va);
    return (va[31:12] == 20'h00007) || (va[31:12] == 20'h0000B);
  endfunction
  function automatic int nbytes_of(input logic [1:0] s);
    return 1 << s;
  endfunction
  function automatic bit crosses(input logic [31:0] va, input int n);
    return (int'(va[11:0]) + n) > 4096;
  endfunction
  function automatic logic [31:0] next_base(input logic [31:0] va);
    return {va[31:12] + 20'd1, 12'h000};
  endfunction
  function automatic logic [63:0] rsp_bytes(input logic [31:0] va, input int n);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = (k < n) ? byte_at(va + 32'(k)) : 8'hEE;
    return r;
  endfunction
  function automatic logic [63:0] load_bytes(input logic [31:0] va, input int n);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = (k < n) ? byte_at(va + 32'(k)) : 8'h00;
    return r;
  endfunction

  // stimulus and downstream queues
  logic [31:0] tq_addr[$];
  logic [1:0]  tq_size[$];
  logic [63:0] rq_data[$];
  bit          rq_fault[$];

  // reference model state
  int          ph = 0;       // 0 idle,1 single wait,2 part-A wait,3 part-B offer,4 part-B wait,5 result hold
  logic [31:0] m_va;
  int          m_n, m_first;
  logic [31:0] m_next;
  bit          m_cross;
  logic [15:0] lf = 16'hACE1;
  bit          took_req, took_rsp;

  task automatic add(input logic [31:0] a, input logic [1:0] s);
    tq_addr.push_back(a);
    tq_size.push_back(s);
  endtask

  initial begin
    logic [31:0] seed;
    int cyc;
    bit e_valid, e_rspr, e_subv, e_fault;
    logic [31:0] e_va, e_faddr;
    int e_n;

    // directed loads
    add(32'h00008A4C, 2'd2);  // inside a page, R1
    add(32'h00001FFE, 2'd2);  // 2 + 2 split, R3 R4
    add(32'h00000FFF, 2'd0);  // last byte of a page, no split, R2
    add(32'h00000FFF, 2'd1);  // 1 + 1 split, R2
    add(32'h00000FF8, 2'd3);  // ends exactly on page end, R2
    add(32'h00000FF9, 2'd3);  // 7 + 1 split, R5
    add(32'h00003FFC, 2'd3);  // 4 + 4 split, R5
    add(32'h00005000, 2'd3);  // page start, R1
    add(32'h00007FFE, 2'd2);  // first part faults, R6
    add(32'h00006FFE, 2'd2);  // second part faults, R7
    add(32'h00007100, 2'd1);  // pass-through fault, R6
    add(32'hFFFFFFFF, 2'd1);  // wrap to page 0, R4
    add(32'h0000AFFD, 2'd3);  // second part into faulting page B, R7
    seed = 32'h1234_5678;
    for (int i = 0; i < 120; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      add({12'h000, seed[19:16], seed[22] ? {9'h1FF, seed[2:0]} : seed[11:0]}, seed[25:24]);
    end

    // reset, R11
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 1'b0, "R11 busy in reset", 64'(busy), 64'h0);
    chk(res_valid == 1'b0, "R11 res_valid in reset", 64'(res_valid), 64'h0);
    chk(sub_valid == 1'b0, "R11 sub_valid in reset", 64'(sub_valid), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    cyc = 0;
    took_req = 0;
    took_rsp = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        chk(1'b0, "R8 watchdog expired", 64'(cyc), 64'h0);
        break;
      end
      if (tq_addr.size() == 0 && ph == 0 && !req_valid && rq_data.size() == 0) break;

      // apply handshakes of the last edge, then drive the next cycle
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (took_req) begin
        void'(tq_addr.pop_front());
        void'(tq_size.pop_front());
        req_valid = 1'b0;
      end
      if (took_rsp) begin
        void'(rq_data.pop_front());
        void'(rq_fault.pop_front());
        sub_rsp_valid = 1'b0;
      end
      took_req = 0;
      took_rsp = 0;
      sub_ready = lf[0] | lf[3];
      res_ready = lf[1] | lf[5];
      if (!req_valid && tq_addr.size() > 0 && lf[4]) begin
        req_valid = 1'b1;
        req_addr  = tq_addr[0];
        req_size  = tq_size[0];
      end
      if (!sub_rsp_valid && rq_data.size() > 0 && (lf[2] | lf[7])) begin
        sub_rsp_valid = 1'b1;
        sub_rsp_data  = rq_data[0];
        sub_rsp_fault = rq_fault[0];
      end
      #1;

      // per-cycle comparison against the model
      chk(busy == (ph != 0), "R8 busy", 64'(busy), 64'(ph != 0));
      chk(req_ready == (ph == 0 && sub_ready), "R8 req_ready", 64'(req_ready), 64'(ph == 0 && sub_ready));
      e_subv = (ph == 0 && req_valid) || ph == 3;
      chk(sub_valid == e_subv, "R1 sub_valid", 64'(sub_valid), 64'(e_subv));
      if (sub_valid && e_subv) begin
        if (ph == 0) begin
          e_n  = nbytes_of(req_size);
          e_va = req_addr;
          if (crosses(req_addr, e_n)) e_n = 4096 - int'(req_addr[11:0]);
          chk(sub_vaddr == e_va, "R1 R3 sub_vaddr", 64'(sub_vaddr), 64'(e_va));
          chk(int'(sub_nbytes) == e_n, "R2 R3 R10 sub_nbytes", 64'(sub_nbytes), 64'(e_n));
        end else begin
          chk(sub_vaddr == m_next, "R4 second part address", 64'(sub_vaddr), 64'(m_next));
          chk(int'(sub_nbytes) == m_n - m_first, "R4 second part count", 64'(sub_nbytes), 64'(m_n - m_first));
        end
      end
      e_rspr = (ph == 1) ? res_ready : (ph == 2 || ph == 4);
      chk(sub_rsp_ready == e_rspr, "R9 sub_rsp_ready", 64'(sub_rsp_ready), 64'(e_rspr));
      e_valid = (ph == 1 && sub_rsp_valid) || ph == 5;
      chk(res_valid == e_valid, "R9 res_valid", 64'(res_valid), 64'(e_valid));
      if (res_valid && e_valid) begin
        e_fault = 0;
        e_faddr = '0;
        if (bad_page(m_va)) begin
          e_fault = 1;
          e_faddr = m_va;
        end else if (m_cross && bad_page(m_next)) begin
          e_fault = 1;
          e_faddr = m_next;
        end
        chk(res_fault == e_fault, "R6 R7 res_fault", 64'(res_fault), 64'(e_fault));
        if (e_fault) begin
          chk(res_fault_addr == e_faddr, "R6 R7 fault address", 64'(res_fault_addr), 64'(e_faddr));
          chk(res_data == 64'h0, "R6 data on fault", res_data, 64'h0);
        end else begin
          chk(res_data == load_bytes(m_va, m_n), "R5 merged data", res_data, load_bytes(m_va, m_n));
        end
      end

      // book the handshakes of the coming edge
      if (ph == 0 && req_valid && sub_ready) begin
        took_req = 1;
        m_va    = req_addr;
        m_n     = nbytes_of(req_size);
        m_cross = crosses(req_addr, m_n);
        m_first = m_cross ? 4096 - int'(req_addr[11:0]) : m_n;
        m_next  = next_base(req_addr);
        rq_data.push_back(rsp_bytes(m_va, m_first));
        rq_fault.push_back(bad_page(m_va));
        ph = m_cross ? 2 : 1;
      end else if (ph == 1 && sub_rsp_valid && res_ready) begin
        took_rsp = 1;
        ph = 0;
      end else if (ph == 2 && sub_rsp_valid) begin
        took_rsp = 1;
        ph = sub_rsp_fault ? 5 : 3;
      end else if (ph == 3 && sub_ready) begin
        rq_data.push_back(rsp_bytes(m_next, m_n - m_first));
        rq_fault.push_back(bad_page(m_next));
        ph = 4;
      end else if (ph == 4 && sub_rsp_valid) begin
        took_rsp = 1;
        ph = 5;
      end else if (ph == 5 && res_ready) begin
        ph = 0;
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule